// File: doc/BRIEF.md
# Double-Buffered Window Configuration Bank

This block holds the configuration of a fixed number of display overlay windows. Each window has two register sets. Software writes the first set, the staging set, through a simple write/read port. The second set, the live set, drives scan-out. The live set changes only in bulk, and only at a frame boundary reported by the timing generator. Because of this, a scan-out never sees a half-written window description.

A global control register has two bits. The first is a hold bit; while it is set, no staging value can reach the live set. The second is a commit-request bit. Writing it with one arms a transfer of every window's staging set, which happens on the next frame-boundary strobe that arrives while the hold bit is clear. The request bit reads back as one until the transfer has taken place, and then clears by itself. Software can therefore raise the hold bit, rewrite any number of windows, request a commit and drop the hold bit, and all the changes land together. The windows are stacked by index, with window 0 at the bottom.

Each window's staging set holds these fields:
- an enable bit and a pixel-format code;
- the top-left and bottom-right corners, each with X in bits 23:12 and Y in bits 11:0, where the bottom-right corner is inclusive (position plus size minus one);
- the first and last buffer addresses;
- a line register with the visible bytes per line in bits 13:0 and the pitch remainder in bits 27:14;
- the framebuffer width in pixels.

The live outputs present these fields unpacked. They also include a burst-size flag derived from the live framebuffer width.

Top module: `shadow_bank`

## Requirements
- R1: After reset, every staging and live field is zero, the hold bit is zero, no commit is pending, `commit_o` is low and the control register reads 0.
- R2: The live outputs of every window keep their value in any cycle that does not commit, whatever is written to the staging registers.
- R3: Writing the control register (address 0) with bit 1 set makes a commit pending; the control register then reads bit 1 as one. On the first rising edge where `frame_tick` is high, a commit is pending and the hold bit (bit 0) is clear, every window's live set takes the staging values held before that edge. Bit 1 then reads zero, and `commit_o` is high for the following cycle.
- R4: While the hold bit is set, a `frame_tick` causes no transfer and the pending request is kept. After the hold bit is written to zero, the next `frame_tick` performs the transfer.
- R5: A `frame_tick` with no pending request changes no live output and leaves `commit_o` low.
- R6: Writing the control register with bit 1 equal to zero does not cancel a pending request.
- R7: Clearing a window's enable bit (bit 0 of its mode register) leaves the live enable at one until a commit takes place.
- R8: Live corner outputs are unpacked from the corner registers: X from bits 23:12 and Y from bits 11:0, with the bottom-right corner passed through as written (inclusive).
- R9: The live visible-bytes output is bits 13:0 of the line register, and the live pitch-remainder output is bits 27:14.
- R10: `act_burst16` for a window is one when its live framebuffer width is 128 or more, and zero otherwise, which selects the 8-word burst.
- R11: Window w (0 to 2) occupies addresses 8*(w+1)+k, with k = 0 for mode (enable in bit 0, format in bits 2:1), 1 for the top-left corner, 2 for the bottom-right corner, 3 for the first address, 4 for the last address, 5 for the line register and 6 for the framebuffer width (bits 13:0). Read data returns the staging value with the unused bits zero. Any other address reads zero and ignores writes.
- R12: A write that sets bit 1 of the control register in the same cycle as a commit leaves a new request pending after that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data (combinational, staging values and control) |
| frame_tick | input | 1 | Frame-boundary strobe from the timing generator |
| commit_o | output | 1 | High for one cycle after a transfer |
| act_en | output | NWIN | Live window enables |
| act_fmt | output | NWIN*2 | Live pixel-format codes |
| act_burst16 | output | NWIN | Live burst flag: 1 = 16 words, 0 = 8 words |
| act_x0 | output | NWIN*12 | Live top-left X |
| act_y0 | output | NWIN*12 | Live top-left Y |
| act_x1 | output | NWIN*12 | Live bottom-right X (inclusive) |
| act_y1 | output | NWIN*12 | Live bottom-right Y (inclusive) |
| act_base | output | NWIN*32 | Live first buffer address |
| act_last | output | NWIN*32 | Live last buffer address |
| act_lsize | output | NWIN*14 | Live visible bytes per line |
| act_loff | output | NWIN*14 | Live pitch remainder per line |

## Verification
The assertions assume the following about the inputs:
- reset is held low across at least one clock edge before any traffic;
- `wr_en`, `wr_addr`, `wr_data` and `frame_tick` carry known values at every rising edge, because the hold-and-commit properties compare live state across edges and would be undefined on unknown strobes.

No ordering between frame strobes and control writes is assumed. Same-cycle commit requests and commits are legal and are exercised on purpose. The bench keeps to these assumptions in three ways:
- it drives every input from tasks on the falling edge, with defined values, from the first cycle;
- it releases reset only after two edges;
- its random phase draws strobes, addresses inside and outside the map, and control values from fixed ranges rather than leaving any input floating.

// File: rtl/wincfg_pkg.sv
package wincfg_pkg;

  localparam int CW     = 12;
  localparam int LW     = 14;
  localparam int FBW    = 14;
  localparam int AW     = 32;
  localparam int DW     = 32;
  localparam int FMT_W  = 2;
  localparam int REG_W  = 3;
  localparam int CRD_W  = 2 * CW;
  localparam int LINE_W = 2 * LW;

  typedef enum logic [REG_W-1:0] {
    WR_MODE  = 3'd0,
    WR_START = 3'd1,
    WR_END   = 3'd2,
    WR_BASE  = 3'd3,
    WR_LAST  = 3'd4,
    WR_LINE  = 3'd5,
    WR_FBW   = 3'd6,
    WR_NONE  = 3'd7
  } wreg_e;

  typedef struct packed {
    logic              en;
    logic [FMT_W-1:0]  fmt;
    logic [CRD_W-1:0]  p0;
    logic [CRD_W-1:0]  p1;
    logic [AW-1:0]     base;
    logic [AW-1:0]     last;
    logic [LINE_W-1:0] line;
    logic [FBW-1:0]    fbw;
  } win_cfg_t;

  function automatic win_cfg_t cfg_write(win_cfg_t c, logic [REG_W-1:0] r,
                                         logic [DW-1:0] d);
    win_cfg_t n;
    n = c;
    case (r)
      WR_MODE:  begin n.en = d[0]; n.fmt = d[FMT_W:1]; end
      WR_START: n.p0   = d[CRD_W-1:0];
      WR_END:   n.p1   = d[CRD_W-1:0];
      WR_BASE:  n.base = d[AW-1:0];
      WR_LAST:  n.last = d[AW-1:0];
      WR_LINE:  n.line = d[LINE_W-1:0];
      WR_FBW:   n.fbw  = d[FBW-1:0];
      default:  ;
    endcase
    return n;
  endfunction

  function automatic logic [DW-1:0] cfg_read(win_cfg_t c, logic [REG_W-1:0] r);
    logic [DW-1:0] v;
    v = '0;
    case (r)
      WR_MODE:  v[FMT_W:0]    = {c.fmt, c.en};
      WR_START: v[CRD_W-1:0]  = c.p0;
      WR_END:   v[CRD_W-1:0]  = c.p1;
      WR_BASE:  v[AW-1:0]     = c.base;
      WR_LAST:  v[AW-1:0]     = c.last;
      WR_LINE:  v[LINE_W-1:0] = c.line;
      WR_FBW:   v[FBW-1:0]    = c.fbw;
      default:  ;
    endcase
    return v;
  endfunction

  function automatic logic [CW-1:0] coord_x(logic [CRD_W-1:0] p);
    return p[CRD_W-1:CW];
  endfunction

  function automatic logic [CW-1:0] coord_y(logic [CRD_W-1:0] p);
    return p[CW-1:0];
  endfunction

  function automatic logic [LW-1:0] line_bytes(logic [LINE_W-1:0] l);
    return l[LW-1:0];
  endfunction

  function automatic logic [LW-1:0] line_gap(logic [LINE_W-1:0] l);
    return l[LINE_W-1:LW];
  endfunction

  function automatic logic wide_burst(logic [FBW-1:0] w, logic [31:0] min_w);
    return ({{(32-FBW){1'b0}}, w} >= min_w);
  endfunction

endpackage

// File: rtl/commit_ctrl.sv
module commit_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_data,
  input  logic       frame_tick,
  output logic       hold_o,
  output logic       pending_o,
  output logic       load_o,
  output logic       commit_o
);

  logic hold_q, pending_q, commit_q;
  logic set_req;
  logic load;

  assign set_req = ctl_wr & ctl_data[1];
  assign load    = frame_tick & pending_q & ~hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      pending_q <= 1'b0;
      commit_q  <= 1'b0;
    end else begin
      if (ctl_wr) hold_q <= ctl_data[0];
      pending_q <= set_req | (pending_q & ~load);
      commit_q  <= load;
    end
  end

  assign hold_o    = hold_q;
  assign pending_o = pending_q;
  assign load_o    = load;
  assign commit_o  = commit_q;

  // R3
  pend_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !set_req) |=> !pending_q);

  // R6
  pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !frame_tick) |=> pending_q);

  // R12
  req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> pending_q);

  // R3
  pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> commit_q);

endmodule

// File: rtl/win_regs.sv
module win_regs
  import wincfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wreg_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             load_i,
  output win_cfg_t         shd_o,
  output win_cfg_t         act_o
);

  win_cfg_t shd_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (load_i) act_q <= shd_q;
      if (wr_i)   shd_q <= cfg_write(shd_q, wreg_i, wdata_i);
    end
  end

  assign shd_o = shd_q;
  assign act_o = act_q;

  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(act_q));

  // R3
  live_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (act_q == $past(shd_q)));

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import wincfg_pkg::*;
#(
  parameter int NWIN        = 3,
  parameter int ADDR_W      = 6,
  parameter int MIN_BURST_W = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  input  logic                frame_tick,
  output logic                commit_o,
  output logic [NWIN-1:0]     act_en,
  output logic [NWIN*2-1:0]   act_fmt,
  output logic [NWIN-1:0]     act_burst16,
  output logic [NWIN*12-1:0]  act_x0,
  output logic [NWIN*12-1:0]  act_y0,
  output logic [NWIN*12-1:0]  act_x1,
  output logic [NWIN*12-1:0]  act_y1,
  output logic [NWIN*32-1:0]  act_base,
  output logic [NWIN*32-1:0]  act_last,
  output logic [NWIN*14-1:0]  act_lsize,
  output logic [NWIN*14-1:0]  act_loff
);

  localparam int SEL_W = ADDR_W - REG_W;

  logic                 hold_w, pending_w, load_w;
  logic                 ctl_wr;
  logic [SEL_W-1:0]     wr_sel, rd_sel;
  logic [REG_W-1:0]     wr_reg, rd_reg;
  win_cfg_t [NWIN-1:0]  shd_all, act_all;

  assign wr_sel = wr_addr[ADDR_W-1:REG_W];
  assign wr_reg = wr_addr[REG_W-1:0];
  assign rd_sel = rd_addr[ADDR_W-1:REG_W];
  assign rd_reg = rd_addr[REG_W-1:0];
  assign ctl_wr = wr_en && (wr_addr == '0);

  commit_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_data   (wr_data[1:0]),
    .frame_tick (frame_tick),
    .hold_o     (hold_w),
    .pending_o  (pending_w),
    .load_o     (load_w),
    .commit_o   (commit_o)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(w + 1));

    win_regs u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (hit),
      .wreg_i  (wr_reg),
      .wdata_i (wr_data),
      .load_i  (load_w),
      .shd_o   (shd_all[w]),
      .act_o   (act_all[w])
    );

    assign act_en[w]                = act_all[w].en;
    assign act_fmt[w*FMT_W +: FMT_W] = act_all[w].fmt;
    assign act_burst16[w]           = wide_burst(act_all[w].fbw, 32'(MIN_BURST_W));
    assign act_x0[w*CW +: CW]       = coord_x(act_all[w].p0);
    assign act_y0[w*CW +: CW]       = coord_y(act_all[w].p0);
    assign act_x1[w*CW +: CW]       = coord_x(act_all[w].p1);
    assign act_y1[w*CW +: CW]       = coord_y(act_all[w].p1);
    assign act_base[w*AW +: AW]     = act_all[w].base;
    assign act_last[w*AW +: AW]     = act_all[w].last;
    assign act_lsize[w*LW +: LW]    = line_bytes(act_all[w].line);
    assign act_loff[w*LW +: LW]     = line_gap(act_all[w].line);
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) begin
      rd_data[1:0] = {pending_w, hold_w};
    end else begin
      for (int w = 0; w < NWIN; w++) begin
        if (rd_sel == SEL_W'(w + 1)) rd_data = cfg_read(shd_all[w], rd_reg);
      end
    end
  end

  // R4
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_w |=> $stable(act_all));

  // R5
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_w |=> ($stable(act_all) && !commit_o));

endmodule

// File: tb/test_shadow_bank.sv
module test_shadow_bank;
  import wincfg_pkg::*;

  localparam int NW = 3;
  localparam int AWD = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, wr_en, frame_tick, commit_o;
  logic [AWD-1:0]    wr_addr, rd_addr;
  logic [31:0]       wr_data, rd_data;
  logic [NW-1:0]     act_en, act_burst16;
  logic [NW*2-1:0]   act_fmt;
  logic [NW*12-1:0]  act_x0, act_y0, act_x1, act_y1;
  logic [NW*32-1:0]  act_base, act_last;
  logic [NW*14-1:0]  act_lsize, act_loff;

  shadow_bank i_shadow_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_tick(frame_tick), .commit_o(commit_o),
    .act_en(act_en), .act_fmt(act_fmt), .act_burst16(act_burst16),
    .act_x0(act_x0), .act_y0(act_y0), .act_x1(act_x1), .act_y1(act_y1),
    .act_base(act_base), .act_last(act_last), .act_lsize(act_lsize), .act_loff(act_loff)
  );

  // behavioural reference: raw register images per window, index = register number
  int unsigned shd [NW][7];
  int unsigned act [NW][7];
  bit m_hold, m_pend, m_commit;
  int n_vec = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  function automatic int unsigned fmask(int r);
    case (r)
      0:       return 32'h7;
      1, 2:    return 32'hFF_FFFF;
      3, 4:    return 32'hFFFF_FFFF;
      5:       return 32'h0FFF_FFFF;
      6:       return 32'h3FFF;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned model_read(int a);
    int sel = a / 8;
    int r = a % 8;
    if (a == 0) return {30'd0, m_pend, m_hold};
    if (sel >= 1 && sel <= NW && r < 7) return shd[sel-1][r];
    return 0;
  endfunction

  function automatic int addr_of(int w, int r);
    return 8 * (w + 1) + r;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp, string what);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, commit_o, m_commit, "commit_o");
    chk(cur_req, rd_data, model_read(int'(rd_addr)), "rd_data");
    for (int w = 0; w < NW; w++) begin
      chk(cur_req, act_en[w], act[w][0] & 1, "act_en");
      chk(cur_req, act_fmt[w*2 +: 2], (act[w][0] >> 1) & 3, "act_fmt");
      chk(cur_req, act_x0[w*12 +: 12], (act[w][1] >> 12) & 32'hFFF, "act_x0");
      chk(cur_req, act_y0[w*12 +: 12], act[w][1] & 32'hFFF, "act_y0");
      chk(cur_req, act_x1[w*12 +: 12], (act[w][2] >> 12) & 32'hFFF, "act_x1");
      chk(cur_req, act_y1[w*12 +: 12], act[w][2] & 32'hFFF, "act_y1");
      chk(cur_req, act_base[w*32 +: 32], act[w][3], "act_base");
      chk(cur_req, act_last[w*32 +: 32], act[w][4], "act_last");
      chk(cur_req, act_lsize[w*14 +: 14], act[w][5] & 32'h3FFF, "act_lsize");
      chk(cur_req, act_loff[w*14 +: 14], (act[w][5] >> 14) & 32'h3FFF, "act_loff");
      chk(cur_req, act_burst16[w], (act[w][6] >= 128) ? 1 : 0, "act_burst16");
    end
  endtask

  task automatic step(bit we, int a, int unsigned d, bit tick, int ra);
    bit c;
    bit setp;
    int sel;
    int r;
    wr_en = we; wr_addr = AWD'(a); wr_data = d; frame_tick = tick; rd_addr = AWD'(ra);
    @(posedge clk);
    c = tick && m_pend && !m_hold;
    if (c) for (int w = 0; w < NW; w++) for (int k = 0; k < 7; k++) act[w][k] = shd[w][k];
    setp = 0;
    if (we) begin
      if (a == 0) begin
        m_hold = d[0];
        setp = d[1];
      end else begin
        sel = a / 8;
        r = a % 8;
        if (sel >= 1 && sel <= NW && r < 7) shd[sel-1][r] = d & fmask(r);
      end
    end
    m_pend = setp || (m_pend && !c);
    m_commit = c;
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(int a, int unsigned d);
    step(1, a, d, 0, a);
  endtask

  task automatic idle(bit tick, int ra);
    step(0, 0, 0, tick, ra);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) for (int k = 0; k < 7; k++) begin shd[w][k] = 0; act[w][k] = 0; end
    m_hold = 0; m_pend = 0; m_commit = 0;
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; frame_tick = 0; rd_addr = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1;

    // R1: reset state
    cur_req = "R1";
    compare_all();
    chk("R1", rd_data, 0, "control after reset");
    chk("R1", act_en, 0, "enables after reset");
    idle(0, addr_of(2, 6));

    // R11: map, masking, unmapped addresses
    cur_req = "R11";
    for (int w = 0; w < NW; w++) for (int k = 0; k < 7; k++) wr(addr_of(w, k), 32'hFFFF_FFFF);
    step(0, 0, 0, 0, addr_of(1, 2));
    chk("R11", rd_data, 32'h00FF_FFFF, "corner read masked");
    step(0, 0, 0, 0, addr_of(0, 5));
    chk("R11", rd_data, 32'h0FFF_FFFF, "line read masked");
    wr(addr_of(0, 7), 32'h1234_5678);
    chk("R11", rd_data, 0, "unmapped slot");
    wr(40, 32'hDEAD_BEEF);
    chk("R11", rd_data, 0, "address past windows");
    wr(3, 32'hFFFF_FFFF);
    chk("R11", rd_data, 0, "gap below first window");

    // R5: ticks with nothing pending
    cur_req = "R5";
    idle(1, 0); idle(1, 0);
    chk("R5", act_en, 0, "no transfer without request");
    chk("R5", commit_o, 0, "no pulse without request");

    // R2: program windows, live side untouched
    cur_req = "R2";
    wr(addr_of(0, 0), 32'h5);
    wr(addr_of(0, 1), (100 << 12) | 20);
    wr(addr_of(0, 2), (149 << 12) | 59);
    wr(addr_of(0, 3), 32'h0001_0000);
    wr(addr_of(0, 4), 32'h0001_0000 + 400 * 40);
    wr(addr_of(0, 5), (200 << 14) | 200);
    wr(addr_of(0, 6), 64);
    wr(addr_of(1, 0), 32'h1);
    wr(addr_of(1, 6), 128);
    wr(addr_of(2, 0), 32'h3);
    wr(addr_of(2, 6), 127);
    idle(0, 0);
    chk("R2", act_x1[0 +: 12], 0, "live unchanged before commit");

    // R3: request and commit
    cur_req = "R3";
    wr(0, 2);
    chk("R3", rd_data, 2, "pending reads one");
    idle(0, 0);
    idle(1, 0);
    chk("R3", commit_o, 1, "commit pulse");
    chk("R3", rd_data, 0, "pending self-clears");
    chk("R8", act_x0[0 +: 12], 100, "top-left X");
    chk("R8", act_y1[0 +: 12], 59, "inclusive bottom Y");
    chk("R8", act_x1[0 +: 12], 149, "inclusive right X");
    chk("R9", act_lsize[0 +: 14], 200, "visible bytes");
    chk("R9", act_loff[0 +: 14], 200, "pitch remainder");
    chk("R10", act_burst16, 3'b010, "burst by width 64/128/127");
    idle(0, 0);

    // R7: disable goes through staging
    cur_req = "R7";
    wr(addr_of(1, 0), 0);
    idle(1, 0);
    chk("R7", act_en[1], 1, "enable held before commit");
    wr(0, 2);
    idle(1, 0);
    chk("R7", act_en[1], 0, "enable cleared on commit");

    // R4: hold blocks transfer, request survives
    cur_req = "R4";
    wr(0, 1);
    wr(addr_of(0, 1), (7 << 12) | 9);
    wr(0, 3);
    idle(1, 0); idle(1, 0); idle(1, 0);
    chk("R4", act_x0[0 +: 12], 100, "no transfer while held");
    chk("R4", rd_data, 3, "held and pending");
    wr(0, 0);
    chk("R4", rd_data, 2, "still pending after release");
    idle(1, 0);
    chk("R4", act_x0[0 +: 12], 7, "transfer after release");

    // R6: writing zero to request bit does not cancel
    cur_req = "R6";
    wr(0, 2);
    wr(0, 0);
    chk("R6", rd_data, 2, "request not cancelled");
    idle(1, 0);
    chk("R6", commit_o, 1, "request still honoured");

    // R12: new request in the commit cycle
    cur_req = "R12";
    wr(addr_of(2, 1), (1 << 12) | 1);
    wr(0, 2);
    step(1, 0, 2, 1, 0);
    chk("R12", commit_o, 1, "commit on same edge");
    chk("R12", rd_data, 2, "new request pending");
    wr(addr_of(2, 1), (2 << 12) | 2);
    idle(1, 0);
    chk("R12", act_x0[24 +: 12], 2, "second commit");
    chk("R12", rd_data, 0, "pending drained");

    // R2: random traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      int a;
      int unsigned d;
      a = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(0, 40);
      d = (a == 0) ? $urandom_range(0, 3) : $urandom;
      step($urandom_range(0, 1), a, d, ($urandom_range(0, 3) == 0), $urandom_range(0, 40));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule